// File: doc/BRIEF.md
# Debug Transmit Channel with Access Trapping

This block holds one 32-bit word on its way from the processor to an external debugger, together with the access check that decides whether a processor write may reach that word. Each write request carries a source tag (register move or memory load), the current privilege level (0 to 3), and a description of the higher levels. That description says whether levels 2 and 3 are present, whether each of levels 1 to 3 runs 64-bit or 32-bit code, and whether the processor is halted or in monitor mode. The request also carries the trap-enable bits that the higher levels program. The block either accepts the write or names exactly one outcome, each outcome with a syndrome code: undefined, trap to level 1, 2 or 3, hypervisor trap, or monitor trap.

The processor side is a valid/ready stream whose ready is held high: the block takes one request per cycle and never applies back-pressure. One cycle after each request, the block reports the verdict on the result pins with a single-cycle valid pulse. The debugger side is also a valid/ready stream. Its valid is the full flag, and the word is handed over in any cycle where valid and ready are both high. If the processor writes a word while the full flag is set, the block does not wait for the debugger. The write goes ahead, and the stored contents become unspecified.

Top module: `dbg_tx_channel`

## Requirements
- R1: An accepted write while the channel is empty stores the 32-bit word. From the next cycle, the word is on rd_data and rd_valid is 1.
- R2: An accepted write while rd_valid is 1 leaves rd_valid at 1. The data contents are then unspecified.
- R3: rd_valid and rd_ready both high clears rd_valid at the next edge. If an accepted write happens in the same cycle, the new word is stored and rd_valid stays 1.
- R4: With halted high, every write is accepted (result code 0), whatever the trap bits are.
- R5: At level 3, the only outcome other than accept is monitor trap (code 6). It is raised when the secure trap bit is set and the processor is not in monitor mode.
- R6: At level 2, the checks run in this order: the fine-grained trap bit with a 64-bit level 3 (trap to level 3, code 4), then the same bit with a 32-bit level 3 (monitor trap, code 6), then the debug-access trap bit with a 64-bit level 3 (code 4). If none fires, the write is accepted.
- R7: At level 1, the level-2 checks come first, and they only apply when level 2 is present. The fine-grained bit is checked first, then a nonzero debug-exception/debug-access pair. A 64-bit level 2 gives trap-to-level-2 (code 3) and a 32-bit level 2 gives hypervisor trap (code 5). The level-3 checks of R6 follow.
- R8: At level 0, the level-1 check comes first. When level 1 is 64-bit and its trap bit is set, the write traps to level 2 if level 2 is present, 64-bit and has trap-general set; otherwise it traps to level 1 (code 2). When level 1 is 32-bit and the user-disable bit is set, the write traps to a 64-bit level 2 with trap-general set, takes a hypervisor trap for a 32-bit level 2 with trap-general set, and is otherwise undefined (code 1). After the level-1 check come the R7 checks, where trap-general also counts toward the pair, and then the level-3 checks.
- R9: The syndrome is 0x05 for a trapped register move and 0x06 for a trapped memory load. It is 0x00 for accept, for undefined, and for the hypervisor trap caused by the user-disable bit.
- R10: res_valid pulses for exactly one cycle, one cycle after each request with wr_valid high, and is 0 otherwise. wr_ready is always 1.
- R11: A write that is not accepted changes neither the stored word nor rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Processor write request |
| wr_ready | output | 1 | Always 1 |
| wr_data | input | 32 | Word to send |
| wr_is_load | input | 1 | 1 = memory load source, 0 = register move |
| priv | input | 2 | Current privilege level |
| halted | input | 1 | Processor halted in debug |
| in_monitor | input | 1 | Level 3 is in monitor mode |
| l1_is64 | input | 1 | Level 1 runs 64-bit code |
| l2_present | input | 1 | Level 2 is present and enabled |
| l2_is64 | input | 1 | Level 2 runs 64-bit code |
| l3_present | input | 1 | Level 3 is present |
| l3_is64 | input | 1 | Level 3 runs 64-bit code |
| l1_trap_comms | input | 1 | Level-1 comms trap bit (64-bit level 1) |
| l1_user_dis | input | 1 | User access disable (32-bit level 1) |
| l2_trap_gen | input | 1 | Level-2 trap-general bit |
| l2_trap_comms | input | 1 | Level-2 fine-grained comms trap |
| l2_trap_dbgexc | input | 1 | Level-2 debug-exception trap |
| l2_trap_dbgacc | input | 1 | Level-2 debug-access trap |
| l3_trap_comms | input | 1 | Level-3 comms trap (fine-grained or secure) |
| l3_trap_dbgacc | input | 1 | Level-3 debug-access trap |
| res_valid | output | 1 | Verdict valid pulse |
| res_kind | output | 3 | 0 accept, 1 undefined, 2 trap L1, 3 trap L2, 4 trap L3, 5 hypervisor, 6 monitor |
| res_syndrome | output | 8 | Syndrome code |
| rd_valid | output | 1 | Full flag: a word is waiting for the debugger |
| rd_ready | input | 1 | Debugger takes the word |
| rd_data | output | 32 | Stored word |

## Verification
The verdict logic is tried against a sweep of every combination of privilege level, level width and presence, the trap bits, and the source tag, with the halted flag clear. The result is compared with a priority model built in the bench. Each combination either separates one rung of the chain from the rung after it or shows the syndrome split between move and load. A thinner sweep with the halted flag set shows that every trap bit is bypassed. Directed sequences exercise the storage side: a write into an empty channel, a write into a full one, a drain, a write and a read in the same cycle, and a refused write into an empty channel. Together they tell apart "stored", "flag only", "cleared" and "untouched".

// File: rtl/dtx_pkg.sv
package dtx_pkg;

  typedef enum logic [2:0] {
    OUT_ACCEPT  = 3'd0,
    OUT_UNDEF   = 3'd1,
    OUT_TRAP_L1 = 3'd2,
    OUT_TRAP_L2 = 3'd3,
    OUT_TRAP_L3 = 3'd4,
    OUT_HYP     = 3'd5,
    OUT_MON     = 3'd6
  } outcome_e;

  localparam int unsigned SYN_W = 8;
  localparam logic [SYN_W-1:0] SYN_MOVE = 8'h05;
  localparam logic [SYN_W-1:0] SYN_LOAD = 8'h06;
  localparam logic [SYN_W-1:0] SYN_NONE = 8'h00;

  typedef struct packed {
    logic l1_is64;
    logic l2_present;
    logic l2_is64;
    logic l3_present;
    logic l3_is64;
  } ctx_t;

  typedef struct packed {
    logic l1_trap_comms;
    logic l1_user_dis;
    logic l2_trap_gen;
    logic l2_trap_comms;
    logic l2_trap_dbgexc;
    logic l2_trap_dbgacc;
    logic l3_trap_comms;
    logic l3_trap_dbgacc;
  } traps_t;

  typedef struct packed {
    outcome_e         kind;
    logic [SYN_W-1:0] syn;
  } verdict_t;

  // Checks owned by level 3, in priority order.
  function automatic outcome_e l3_checks(ctx_t c, traps_t t);
    outcome_e r;
    r = OUT_ACCEPT;
    if (c.l3_present && c.l3_is64 && t.l3_trap_comms)       r = OUT_TRAP_L3;
    else if (c.l3_present && !c.l3_is64 && t.l3_trap_comms) r = OUT_MON;
    else if (c.l3_present && c.l3_is64 && t.l3_trap_dbgacc) r = OUT_TRAP_L3;
    return r;
  endfunction

  // Checks owned by level 2; trap-general joins the pair only for level 0.
  function automatic outcome_e l2_checks(ctx_t c, traps_t t, logic with_gen);
    outcome_e r;
    logic     pair;
    pair = t.l2_trap_dbgexc | t.l2_trap_dbgacc | (with_gen & t.l2_trap_gen);
    r = OUT_ACCEPT;
    if (c.l2_present && c.l2_is64 && t.l2_trap_comms)       r = OUT_TRAP_L2;
    else if (c.l2_present && !c.l2_is64 && t.l2_trap_comms) r = OUT_HYP;
    else if (c.l2_present && c.l2_is64 && pair)             r = OUT_TRAP_L2;
    else if (c.l2_present && !c.l2_is64 && pair)            r = OUT_HYP;
    return r;
  endfunction

endpackage

// File: rtl/dtx_access_check.sv
module dtx_access_check
  import dtx_pkg::*;
(
  input  logic [1:0] priv,
  input  logic       halted,
  input  logic       in_monitor,
  input  logic       is_load,
  input  ctx_t       ctx,
  input  traps_t     traps,
  output verdict_t   verdict
);

  outcome_e kind;
  logic     zero_syn;
  outcome_e k2;
  outcome_e k3;

  always_comb begin
    zero_syn = 1'b0;
    kind     = OUT_ACCEPT;
    k2       = l2_checks(ctx, traps, (priv == 2'd0));
    k3       = l3_checks(ctx, traps);
    if (!halted) begin
      unique case (priv)
        2'd3: begin
          if (!in_monitor && traps.l3_trap_comms) kind = OUT_MON;
        end
        2'd2: kind = k3;
        2'd1: kind = (k2 != OUT_ACCEPT) ? k2 : k3;
        default: begin
          if (ctx.l1_is64 && traps.l1_trap_comms) begin
            kind = (ctx.l2_present && ctx.l2_is64 && traps.l2_trap_gen)
                   ? OUT_TRAP_L2 : OUT_TRAP_L1;
          end else if (!ctx.l1_is64 && traps.l1_user_dis) begin
            if (ctx.l2_present && ctx.l2_is64 && traps.l2_trap_gen) begin
              kind = OUT_TRAP_L2;
            end else if (ctx.l2_present && !ctx.l2_is64 && traps.l2_trap_gen) begin
              kind     = OUT_HYP;
              zero_syn = 1'b1;
            end else begin
              kind = OUT_UNDEF;
            end
          end else begin
            kind = (k2 != OUT_ACCEPT) ? k2 : k3;
          end
        end
      endcase
    end
  end

  always_comb begin
    verdict.kind = kind;
    if (kind == OUT_ACCEPT || kind == OUT_UNDEF || zero_syn) verdict.syn = SYN_NONE;
    else verdict.syn = is_load ? SYN_LOAD : SYN_MOVE;
  end

endmodule

// File: rtl/dtx_store.sv
module dtx_store #(
  parameter int unsigned W              = 32,
  parameter bit          KEEP_ON_REFILL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_word,
  input  logic         rd_ready,
  output logic         full,
  output logic [W-1:0] word
);

  logic rd_fire;
  logic take_new;

  assign rd_fire = full & rd_ready;

  // Policy for a write into a full register (contents unspecified either way).
  generate
    if (KEEP_ON_REFILL) begin : g_keep
      assign take_new = ~full | rd_fire;
    end else begin : g_take
      assign take_new = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      word <= '0;
    end else if (wr_en) begin
      full <= 1'b1;
      if (take_new) word <= wr_word;
    end else if (rd_fire) begin
      full <= 1'b0;
    end
  end

endmodule

// File: rtl/dtx_result_reg.sv
module dtx_result_reg
  import dtx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  verdict_t         verdict,
  output logic             res_valid,
  output logic [2:0]       res_kind,
  output logic [SYN_W-1:0] res_syndrome
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_kind     <= 3'd0;
      res_syndrome <= '0;
    end else begin
      res_valid <= req;
      if (req) begin
        res_kind     <= verdict.kind;
        res_syndrome <= verdict.syn;
      end
    end
  end

endmodule

// File: rtl/dbg_tx_channel.sv
module dbg_tx_channel
  import dtx_pkg::*;
#(
  parameter int unsigned DATA_W         = 32,
  parameter bit          KEEP_ON_REFILL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_is_load,
  input  logic [1:0]        priv,
  input  logic              halted,
  input  logic              in_monitor,
  input  logic              l1_is64,
  input  logic              l2_present,
  input  logic              l2_is64,
  input  logic              l3_present,
  input  logic              l3_is64,
  input  logic              l1_trap_comms,
  input  logic              l1_user_dis,
  input  logic              l2_trap_gen,
  input  logic              l2_trap_comms,
  input  logic              l2_trap_dbgexc,
  input  logic              l2_trap_dbgacc,
  input  logic              l3_trap_comms,
  input  logic              l3_trap_dbgacc,
  output logic              res_valid,
  output logic [2:0]        res_kind,
  output logic [7:0]        res_syndrome,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data
);

  ctx_t     ctx;
  traps_t   traps;
  verdict_t verdict;
  logic     accept;

  assign wr_ready = 1'b1;

  assign ctx = '{l1_is64: l1_is64, l2_present: l2_present, l2_is64: l2_is64,
                 l3_present: l3_present, l3_is64: l3_is64};

  assign traps = '{l1_trap_comms: l1_trap_comms, l1_user_dis: l1_user_dis,
                   l2_trap_gen: l2_trap_gen, l2_trap_comms: l2_trap_comms,
                   l2_trap_dbgexc: l2_trap_dbgexc, l2_trap_dbgacc: l2_trap_dbgacc,
                   l3_trap_comms: l3_trap_comms, l3_trap_dbgacc: l3_trap_dbgacc};

  dtx_access_check u_check (
    .priv       (priv),
    .halted     (halted),
    .in_monitor (in_monitor),
    .is_load    (wr_is_load),
    .ctx        (ctx),
    .traps      (traps),
    .verdict    (verdict)
  );

  assign accept = wr_valid & (verdict.kind == OUT_ACCEPT);

  dtx_store #(.W(DATA_W), .KEEP_ON_REFILL(KEEP_ON_REFILL)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (accept),
    .wr_word  (wr_data),
    .rd_ready (rd_ready),
    .full     (rd_valid),
    .word     (rd_data)
  );

  dtx_result_reg u_result (
    .clk          (clk),
    .rst_n        (rst_n),
    .req          (wr_valid),
    .verdict      (verdict),
    .res_valid    (res_valid),
    .res_kind     (res_kind),
    .res_syndrome (res_syndrome)
  );

endmodule

// File: rtl/dtx_checker.sv
module dtx_checker #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [DATA_W-1:0] wr_data,
  input logic              halted,
  input logic              res_valid,
  input logic [2:0]        res_kind,
  input logic [7:0]        res_syndrome,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data
);

  // R10
  res_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> res_valid);

  // R10
  res_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> !res_valid);

  // R10
  always_ff @(posedge clk) begin
    if (rst_n) ready_high_chk: assert (wr_ready);
  end

  // R4
  halted_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && halted) |=> (res_valid && res_kind == 3'd0));

  // R2
  accept_sets_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == 3'd0) |-> rd_valid);

  // R1
  empty_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && halted && !rd_valid) |=> (rd_valid && rd_data == $past(wr_data)));

  // R3
  drain_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && !wr_valid) |=> !rd_valid);

  // R9
  syndrome_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_kind == 3'd0 || res_kind == 3'd1)) |-> res_syndrome == 8'h00);

  // R9
  syndrome_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind >= 3'd2 && res_kind != 3'd5)
      |-> (res_syndrome == 8'h05 || res_syndrome == 8'h06));

  // R11
  refused_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !halted && !rd_valid && !$past(wr_valid)) |=>
      ((res_kind != 3'd0) |-> !rd_valid));

endmodule

bind dbg_tx_channel dtx_checker #(.DATA_W(DATA_W)) u_dtx_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .wr_data      (wr_data),
  .halted       (halted),
  .res_valid    (res_valid),
  .res_kind     (res_kind),
  .res_syndrome (res_syndrome),
  .rd_valid     (rd_valid),
  .rd_ready     (rd_ready),
  .rd_data      (rd_data)
);

// File: tb/test_dbg_tx_channel.sv
`timescale 1ns/1ps
module test_dbg_tx_channel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [31:0] wr_data = '0;
  logic        wr_is_load = 1'b0;
  logic [1:0]  priv = 2'd0;
  logic        halted = 1'b0, in_monitor = 1'b0;
  logic        l1_is64 = 1'b0, l2_present = 1'b0, l2_is64 = 1'b0;
  logic        l3_present = 1'b0, l3_is64 = 1'b0;
  logic        l1_trap_comms = 1'b0, l1_user_dis = 1'b0, l2_trap_gen = 1'b0;
  logic        l2_trap_comms = 1'b0, l2_trap_dbgexc = 1'b0, l2_trap_dbgacc = 1'b0;
  logic        l3_trap_comms = 1'b0, l3_trap_dbgacc = 1'b0;
  logic        res_valid;
  logic [2:0]  res_kind;
  logic [7:0]  res_syndrome;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [31:0] rd_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dbg_tx_channel i_dbg_tx_channel (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Sweep word bit layout: [1:0] priv, 2 l1_is64, 3 l2_present, 4 l2_is64,
  // 5 l3_present, 6 l3_is64, 7 l1_trap_comms (also in_monitor), 8 l1_user_dis,
  // 9 l2_trap_gen, 10 l2_trap_comms, 11 l2_trap_dbgexc, 12 l2_trap_dbgacc,
  // 13 l3_trap_comms, 14 l3_trap_dbgacc, 15 is_load.
  task automatic apply(input logic [15:0] v);
    priv = v[1:0]; l1_is64 = v[2]; l2_present = v[3]; l2_is64 = v[4];
    l3_present = v[5]; l3_is64 = v[6]; l1_trap_comms = v[7]; in_monitor = v[7];
    l1_user_dis = v[8]; l2_trap_gen = v[9]; l2_trap_comms = v[10];
    l2_trap_dbgexc = v[11]; l2_trap_dbgacc = v[12]; l3_trap_comms = v[13];
    l3_trap_dbgacc = v[14]; wr_is_load = v[15];
  endtask

  // Expected verdict: {kind[2:0], syndrome[7:0]}
  function automatic logic [10:0] model(input logic [15:0] v, input logic h);
    int   k = 0;
    bit   z = 0;
    logic [7:0] s;
    bit   l3a, l2x;
    l2x = v[11] | v[12] | ((v[1:0] == 2'd0) & v[9]);
    if (v[5] && v[6] && v[13]) l3a = 1; else l3a = 0;
    if (h) k = 0;
    else if (v[1:0] == 2'd3) k = (!v[7] && v[13]) ? 6 : 0;
    else begin
      if (v[1:0] == 2'd0 && v[2] && v[7]) k = (v[3] && v[4] && v[9]) ? 3 : 2;
      else if (v[1:0] == 2'd0 && !v[2] && v[8]) begin
        if (v[3] && v[4] && v[9]) k = 3;
        else if (v[3] && !v[4] && v[9]) begin k = 5; z = 1; end
        else k = 1;
      end else begin
        if (v[1:0] != 2'd2 && v[3] && v[10]) k = v[4] ? 3 : 5;
        else if (v[1:0] != 2'd2 && v[3] && l2x) k = v[4] ? 3 : 5;
        else if (l3a) k = 4;
        else if (v[5] && !v[6] && v[13]) k = 6;
        else if (v[5] && v[6] && v[14]) k = 4;
        else k = 0;
      end
    end
    if (k == 0 || k == 1 || z) s = 8'h00;
    else s = v[15] ? 8'h06 : 8'h05;
    return {k[2:0], s};
  endfunction

  task automatic write_cycle(input logic [31:0] d);
    wr_valid = 1'b1; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    string tag [4] = '{"R8", "R7", "R6", "R5"};
    logic [10:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset rd_valid", rd_valid, 0);
    check("R10 reset res_valid", res_valid, 0);
    check("R10 wr_ready", wr_ready, 1);

    apply(16'h0003);   // level 3, monitor off, no traps
    write_cycle(32'hA5A5_0001);
    check("R1 accept kind", res_kind, 0);
    check("R1 rd_valid", rd_valid, 1);
    check("R1 rd_data", rd_data, 32'hA5A5_0001);
    write_cycle(32'h1234_5678);
    check("R2 full stays", rd_valid, 1);
    rd_ready = 1'b1; @(posedge clk); @(negedge clk); rd_ready = 1'b0;
    check("R3 drain clears", rd_valid, 0);
    check("R10 single pulse", res_valid, 0);

    apply(16'h2003);   // level 3, secure trap on, not in monitor
    write_cycle(32'hDEAD_BEEF);
    check("R5 monitor trap", res_kind, 6);
    check("R11 refused keeps empty", rd_valid, 0);
    halted = 1'b1;
    write_cycle(32'h0BAD_F00D);
    check("R4 halted accept", res_kind, 0);
    check("R4 halted store", rd_data, 32'h0BAD_F00D);
    rd_ready = 1'b1;
    write_cycle(32'h7777_0000);
    check("R3 write wins flag", rd_valid, 1);
    check("R3 write wins data", rd_data, 32'h7777_0000);
    @(posedge clk); @(negedge clk);
    check("R3 drained", rd_valid, 0);
    halted = 1'b0;

    // Full sweep, not halted, debugger always draining
    for (int i = 0; i < 65536; i++) begin
      apply(i[15:0]);
      wr_valid = 1'b1; wr_data = i;
      @(posedge clk); @(negedge clk);
      e = model(i[15:0], 1'b0);
      check(tag[i[1:0]], {29'd0, res_kind}, {29'd0, e[10:8]});
      check("R9 syndrome", {24'd0, res_syndrome}, {24'd0, e[7:0]});
      check("R10 valid", res_valid, 1);
    end
    wr_valid = 1'b0;

    // Halted bypass over a spread of trap settings
    halted = 1'b1;
    for (int i = 0; i < 65536; i += 257) begin
      apply(i[15:0] | 16'h7F80);
      wr_valid = 1'b1;
      @(posedge clk); @(negedge clk);
      check("R4 halted bypass", res_kind, 0);
    end
    wr_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R10 idle no pulse", res_valid, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule